// File: doc/BRIEF.md
# Bitwise Majority Disparity Voter

This block refines a disparity map by replacing each centre disparity with an estimate of the most frequent valid disparity in its 25x25 neighbourhood. An upstream line store presents one full column of the window per clock: 25 disparity values of 6 bits each, every one with its own valid flag. The block first reduces that column to one voted disparity and a validity flag. It then keeps the 25 most recent column results in a shift register and votes across them to produce the refined centre value.

The mode is approximated bit by bit. For each of the 6 bit positions, only valid entries are counted, and the bit is set when strictly more than half of those entries carry a one. Column results with no valid entry take no part in the horizontal vote. When nothing in the window is valid, the block passes the original centre disparity through and marks it invalid. The upstream logic fills the window edges: it sends 12 columns with all valid flags low before and after each row, so that the first and last centres of a row see a full window.

Top module: `disp_vote_top`

## Requirements
- R1: In a column, bit b of the column result is 1 when the number of valid entries whose bit b is 1, times two, is greater than the number of valid entries. Otherwise bit b is 0, so a tie gives 0. Entry i occupies `col_disp[6*i +: 6]` and has its valid flag in `col_valid[i]`.
- R2: Entries whose valid flag is low have no effect on the result, whatever their disparity value.
- R3: A column result is valid when at least one of its entries is valid. Only valid column results are counted in the horizontal vote.
- R4: The horizontal vote applies the rule of R1 to the 25 stored column results, index 0 being the newest. The result is shown on `out_disp`, with `out_valid` high.
- R5: When none of the 25 column results is valid, `out_disp` equals entry 12 of the column accepted 12 shifts before the newest one, and `out_valid` is low.
- R6: A column accepted with `in_en` high at a clock edge produces `out_vld` high after the next edge. The result covers the window made of that column and the 24 columns accepted before it.
- R7: A cycle with `in_en` low shifts nothing. It produces `out_vld` low two edges later, and `out_disp` keeps its value.
- R8: After reset `out_vld`, `out_valid` and `out_disp` are 0, and every stored column result is invalid with disparity 0.
- R9: A new column is accepted on every cycle in which `in_en` is high, back to back, with no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_en | input | 1 | A column is presented this cycle |
| col_disp | input | 150 | 25 disparities of 6 bits, entry i at bits 6*i+5..6*i, entry 12 is the centre row |
| col_valid | input | 25 | Valid flag per entry |
| out_vld | output | 1 | Refined result present |
| out_disp | output | 6 | Refined centre disparity |
| out_valid | output | 1 | Refined disparity came from at least one valid entry |

## Verification
The assertions assume that the column inputs are defined and stable around the sampling edge whenever `in_en` is high. They also assume that `in_en` is never unknown once reset has been released. The latency and idle properties rely on `in_en` staying known after reset. The stimulus drives every input on the falling edge only and holds `in_en` at a defined 0 or 1 at all times. The stimulus also supplies the invalid padding columns itself. These include an all-invalid window, unanimous and split columns, ties and columns holding invalid entries with arbitrary values. Long random stretches mix dense and sparse valid flags with idle gaps.

// File: rtl/dv_pkg.sv
// Shared sizing for the disparity voter.
// Assumes a square window with an odd side length.
package dv_pkg;
    localparam int DV_WIN = 25;  // window side: entries per column and number of columns
    localparam int DV_DW  = 6;   // disparity width in bits
endpackage

// File: rtl/dv_bit_vote.sv
// Bitwise majority vote over N entries. Only entries flagged valid are counted.
// For each bit, the result bit is 1 when the ones among the valid entries are more
// than half of the valid entries. Purely combinational.
// Assumes N >= 1. The result disparity is 0 when no entry is valid.
module dv_bit_vote #(
    parameter int N  = 25,
    parameter int DW = 6
) (
    input  logic [N*DW-1:0] disp_i,
    input  logic [N-1:0]    ok_i,
    output logic [DW-1:0]   disp_o,
    output logic            ok_o
);
    localparam int CW = $clog2(N + 1);

    logic [CW-1:0] n_valid;

    // count the valid entries
    always_comb begin
        n_valid = '0;
        for (int i = 0; i < N; i++) begin
            n_valid = n_valid + CW'(ok_i[i]);
        end
    end

    assign ok_o = (n_valid != '0);

    // one independent counter and compare per bit position
    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic [CW-1:0] n_ones;
        // count the valid entries that carry a one in this bit
        always_comb begin
            n_ones = '0;
            for (int i = 0; i < N; i++) begin
                n_ones = n_ones + CW'(ok_i[i] & disp_i[i*DW + b]);
            end
        end
        assign disp_o[b] = ({n_ones, 1'b0} > {1'b0, n_valid});
    end
endmodule

// File: rtl/dv_col_shift.sv
// Shift register of column results with the original centre entry of each column.
// Stage 0 holds the newest column. On en, every stage moves one place along.
// The centre output taps stage HALF.
// Assumes WIN is odd. Reset clears every stage to invalid with value 0.
module dv_col_shift #(
    parameter int WIN = 25,
    parameter int DW  = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [DW-1:0]    res_disp_i,
    input  logic             res_ok_i,
    input  logic [DW-1:0]    ctr_i,
    output logic [WIN*DW-1:0] win_disp_o,
    output logic [WIN-1:0]   win_ok_o,
    output logic [DW-1:0]    ctr_o
);
    localparam int HALF = WIN / 2;

    logic [DW-1:0] st_disp [WIN];
    logic          st_ok   [WIN];
    logic [DW-1:0] st_ctr  [WIN];

    for (genvar s = 0; s < WIN; s++) begin : g_stage
        // load stage s from its upstream neighbour or from the new column
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_disp[s] <= '0;
                st_ok[s]   <= 1'b0;
                st_ctr[s]  <= '0;
            end else if (en) begin
                if (s == 0) begin
                    st_disp[s] <= res_disp_i;
                    st_ok[s]   <= res_ok_i;
                    st_ctr[s]  <= ctr_i;
                end else begin
                    st_disp[s] <= st_disp[(s == 0) ? 0 : s-1];
                    st_ok[s]   <= st_ok[(s == 0) ? 0 : s-1];
                    st_ctr[s]  <= st_ctr[(s == 0) ? 0 : s-1];
                end
            end
        end
        assign win_disp_o[s*DW +: DW] = st_disp[s];
        assign win_ok_o[s]            = st_ok[s];
    end

    assign ctr_o = st_ctr[HALF];
endmodule

// File: rtl/disp_vote_top.sv
// Valid-aware disparity voter over a WIN x WIN window.
// Each accepted column is reduced by a column vote, then pushed into a shift register.
// A horizontal vote over the stored results yields the refined centre disparity
// two edges after the column was accepted.
// Assumes the caller sends HALF all-invalid padding columns at each row edge.
module disp_vote_top #(
    parameter int WIN = dv_pkg::DV_WIN,
    parameter int DW  = dv_pkg::DV_DW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_en,
    input  logic [WIN*DW-1:0] col_disp,
    input  logic [WIN-1:0]    col_valid,
    output logic              out_vld,
    output logic [DW-1:0]     out_disp,
    output logic              out_valid
);
    localparam int HALF = WIN / 2;

    logic [DW-1:0]     cres_disp;
    logic              cres_ok;
    logic [WIN*DW-1:0] win_disp;
    logic [WIN-1:0]    win_ok;
    logic [DW-1:0]     ctr_q;
    logic [DW-1:0]     row_disp;
    logic              row_ok;
    logic              shift_d;

    dv_bit_vote #(.N(WIN), .DW(DW)) u_col (
        .disp_i (col_disp),
        .ok_i   (col_valid),
        .disp_o (cres_disp),
        .ok_o   (cres_ok)
    );

    dv_col_shift #(.WIN(WIN), .DW(DW)) u_shift (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (in_en),
        .res_disp_i (cres_disp),
        .res_ok_i   (cres_ok),
        .ctr_i      (col_disp[HALF*DW +: DW]),
        .win_disp_o (win_disp),
        .win_ok_o   (win_ok),
        .ctr_o      (ctr_q)
    );

    dv_bit_vote #(.N(WIN), .DW(DW)) u_row (
        .disp_i (win_disp),
        .ok_i   (win_ok),
        .disp_o (row_disp),
        .ok_o   (row_ok)
    );

    // remember that the window moved, so the result register loads next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) shift_d <= 1'b0;
        else        shift_d <= in_en;
    end

    // register the refined disparity, falling back to the centre when nothing is valid
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld   <= 1'b0;
            out_disp  <= '0;
            out_valid <= 1'b0;
        end else begin
            out_vld <= shift_d;
            if (shift_d) begin
                out_disp  <= row_ok ? row_disp : ctr_q;
                out_valid <= row_ok;
            end
        end
    end
endmodule

// File: rtl/dv_vote_chk.sv
// Property checker for disp_vote_top, attached through bind.
// Assumes in_en is known once reset has been released.
module dv_vote_chk #(
    parameter int WIN = 25,
    parameter int DW  = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_en,
    input logic [WIN*DW-1:0] col_disp,
    input logic [WIN-1:0]    col_valid,
    input logic [DW-1:0]     cres_disp,
    input logic              cres_ok,
    input logic [DW-1:0]     ctr_q,
    input logic              out_vld,
    input logic [DW-1:0]     out_disp,
    input logic              out_valid
);
    logic unanimous;

    // detect a column whose entries are all valid and all equal to entry 0
    always_comb begin
        unanimous = &col_valid;
        for (int i = 1; i < WIN; i++) begin
            if (col_disp[i*DW +: DW] != col_disp[DW-1:0]) unanimous = 1'b0;
        end
    end

    p_col_unanimous_r1: assert property (@(posedge clk) disable iff (!rst_n)
        unanimous |-> (cres_ok && cres_disp == col_disp[DW-1:0]));

    p_col_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid == '0) |-> !cres_ok);

    p_keep_centre_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && !out_valid) |-> (out_disp == $past(ctr_q)));

    p_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        in_en |-> ##2 out_vld);

    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !in_en |-> ##2 (!out_vld && $stable(out_disp)));
endmodule

bind disp_vote_top dv_vote_chk #(.WIN(WIN), .DW(DW)) u_chk (.*);

// File: tb/sim_disp_vote_top.sv
// Scoreboard bench: the driver computes the expected result from the requirements,
// and a monitor compares it with the output on the falling edge.
module sim_disp_vote_top;
    localparam int WIN  = 25;
    localparam int DW   = 6;
    localparam int HALF = WIN / 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_en = 1'b0;
    logic [WIN*DW-1:0] col_disp = '0;
    logic [WIN-1:0]    col_valid = '0;
    logic              out_vld;
    logic [DW-1:0]     out_disp;
    logic              out_valid;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [DW-1:0] cd [WIN];
    logic          cv [WIN];
    logic [DW-1:0] w_d [WIN];
    logic          w_v [WIN];
    logic [DW-1:0] w_c [WIN];

    logic [DW:0] exp_q [$];
    string       tag_q [$];
    string       cur_tag = "R1 R4";
    logic [DW-1:0] last_disp = '0;
    bit            track_idle = 1'b0;

    always #5 clk = ~clk;

    disp_vote_top #(.WIN(WIN), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_en(in_en), .col_disp(col_disp),
        .col_valid(col_valid), .out_vld(out_vld), .out_disp(out_disp), .out_valid(out_valid)
    );

    // reference vote built from R1: {valid, disparity}
    function automatic logic [DW:0] ref_vote(input logic [DW-1:0] d [WIN], input logic v [WIN]);
        int n = 0;
        logic [DW-1:0] r = '0;
        for (int i = 0; i < WIN; i++) n += int'(v[i]);
        for (int b = 0; b < DW; b++) begin
            int c = 0;
            for (int i = 0; i < WIN; i++) c += int'(v[i] & d[i][b]);
            r[b] = (2 * c > n);
        end
        return {n > 0, r};
    endfunction

    task automatic check(input string req, input logic [DW:0] act, input logic [DW:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual valid=%0b disp=%0d expected valid=%0b disp=%0d",
                     req, act[DW], act[DW-1:0], exp[DW], exp[DW-1:0]);
        end
    endtask

    // driver: present one column from cd/cv and queue the expected refined result
    task automatic push_col();
        logic [DW:0] cr;
        logic [DW:0] hr;
        @(negedge clk);
        in_en = 1'b1;
        for (int i = 0; i < WIN; i++) begin
            col_disp[i*DW +: DW] = cd[i];
            col_valid[i]         = cv[i];
        end
        cr = ref_vote(cd, cv);
        for (int s = WIN - 1; s > 0; s--) begin
            w_d[s] = w_d[s-1]; w_v[s] = w_v[s-1]; w_c[s] = w_c[s-1];
        end
        w_d[0] = cr[DW-1:0]; w_v[0] = cr[DW]; w_c[0] = cd[HALF];
        hr = ref_vote(w_d, w_v);
        exp_q.push_back(hr[DW] ? hr : {1'b0, w_c[HALF]});
        tag_q.push_back(hr[DW] ? cur_tag : "R5");
    endtask

    task automatic idle_col();
        @(negedge clk);
        in_en = 1'b0;
        col_valid = '0;
    endtask

    task automatic pad_cols(input int n);
        for (int k = 0; k < n; k++) begin
            for (int i = 0; i < WIN; i++) begin cd[i] = DW'($urandom); cv[i] = 1'b0; end
            push_col();
        end
    endtask

    // monitor: pop and compare results, and check that idle cycles hold the output
    always @(negedge clk) begin
        if (rst_n && out_vld) begin
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL R6: actual out_vld=1 expected out_vld=0 (no result due)");
            end else begin
                check(tag_q.pop_front(), {out_valid, out_disp}, exp_q.pop_front());
            end
            last_disp = out_disp;
        end else if (rst_n && track_idle) begin
            check("R7", {out_vld, out_disp}, {1'b0, last_disp});
        end
    end

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual still running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < WIN; s++) begin w_d[s] = '0; w_v[s] = 1'b0; w_c[s] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R8", {out_vld, out_valid, out_disp}, '0);

        // R5: all-invalid window, centre values differ per column
        for (int k = 0; k < WIN + 5; k++) begin
            for (int i = 0; i < WIN; i++) begin cd[i] = DW'(k + i); cv[i] = 1'b0; end
            push_col();
        end

        // R1 R4: unanimous valid columns of value 37
        cur_tag = "R1 R4 unanimous";
        for (int k = 0; k < WIN + 3; k++) begin
            for (int i = 0; i < WIN; i++) begin cd[i] = 6'd37; cv[i] = 1'b1; end
            push_col();
        end
        pad_cols(WIN);

        // R1 R2 R3: a lone majority column (3 of 5 valid say 63), invalid entries hold garbage
        cur_tag = "R1 R2 R3 lone column";
        for (int i = 0; i < WIN; i++) begin cd[i] = 6'd21; cv[i] = 1'b0; end
        cd[0] = 6'd63; cd[3] = 6'd63; cd[7] = 6'd63; cd[9] = 6'd0; cd[20] = 6'd0;
        cv[0] = 1'b1; cv[3] = 1'b1; cv[7] = 1'b1; cv[9] = 1'b1; cv[20] = 1'b1;
        push_col();
        pad_cols(WIN);

        // R1 tie: two valid entries 63 and 0 give 0 in every bit
        cur_tag = "R1 tie";
        for (int i = 0; i < WIN; i++) begin cd[i] = 6'd42; cv[i] = 1'b0; end
        cd[4] = 6'd63; cd[18] = 6'd0; cv[4] = 1'b1; cv[18] = 1'b1;
        push_col();
        pad_cols(WIN);

        // R2 R3 R4 R9: random rows, back to back, with sparse and dense valid flags
        cur_tag = "R2 R3 R4 R9 random";
        for (int row = 0; row < 8; row++) begin
            int dens = (row % 3 == 0) ? 2 : ((row % 3 == 1) ? 10 : 50);
            pad_cols(HALF);
            for (int k = 0; k < 40; k++) begin
                for (int i = 0; i < WIN; i++) begin
                    cd[i] = DW'($urandom);
                    cv[i] = (($urandom % 100) < dens);
                end
                push_col();
            end
            pad_cols(HALF);
        end

        // R6 R7: columns with idle gaps between them
        cur_tag = "R6 R7 gaps";
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < WIN; i++) begin
                cd[i] = DW'($urandom % 8);
                cv[i] = (($urandom % 4) != 0);
            end
            push_col();
            if (k % 3 == 0) idle_col();
        end
        idle_col();
        idle_col();
        idle_col();

        // R7: long idle stretch, the output must stay quiet and hold
        track_idle = 1'b1;
        repeat (6) idle_col();
        track_idle = 1'b0;

        if (exp_q.size() != 0) begin
            checks++; fails++;
            $display("FAIL R6: actual %0d results missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule